// File: doc/BRIEF.md
# Temperature-Indexed Resistor Code Selector

This block produces an 8-bit code for each of two variable resistors. With temperature indexing on, each new temperature sample becomes a table index in 2 °C steps starting at -40 °C. The block issues one read strobe with a table address. The two per-resistor lookup memories return one byte each. Both resistor codes are then loaded together. With temperature indexing off, the codes follow two manual setting registers instead.

The lookup memories sit outside the block. They are synchronous RAMs that share one address bus. Each one returns its byte on the cycle after the strobe. Each table fills offsets 80h to C7h of its own page, one entry per temperature step, 72 entries in all. The analog ladder, the sensor and the host access path are outside this block.

Top module: `tcr_code_sel`

## Requirements
- R1: While reset is asserted and after it is released, both codes are 00h and the strobe is low. The block stays in manual behaviour until `temp_en_i` is 1.
- R2: The temperature is an 8-bit two's-complement integer in °C. For an accepted sample T, the address is 80h + ((T + 40) >> 1).
- R3: A sample below -40 °C gives address 80h, which is index 0.
- R4: A sample at or above +102 °C gives address C7h, which is index 71.
- R5: The strobe `lut_rd_o` is high for exactly the cycle after each cycle in which `temp_valid_i` and `temp_en_i` are both 1. At all other times it is low, so no lookup starts while indexing is off.
- R6: The memories return data on the cycle after the strobe. On the next edge, `code0_o` takes `lut_data0_i` and `code1_o` takes `lut_data1_i`, both in the same cycle, three edges after the sample.
- R7: While `temp_en_i` is 0, each code equals its manual register, `man_code0_i` or `man_code1_i`, one clock later.
- R8: Clearing `temp_en_i` while a lookup is in flight gives manual codes from the next clock on. The data of that lookup is discarded.
- R9: While indexing is on, the codes hold their value between table loads. This includes the cycles after indexing is turned on and before the first lookup completes.
- R10: Samples on consecutive cycles each produce their own load, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_valid_i | input | 1 | New temperature sample present |
| temp_i | input | 8 | Temperature, signed °C |
| temp_en_i | input | 1 | 1: temperature indexing, 0: manual |
| man_code0_i | input | 8 | Manual code for resistor 0 |
| man_code1_i | input | 8 | Manual code for resistor 1 |
| lut_rd_o | output | 1 | Table read strobe |
| lut_addr_o | output | 8 | Table address (80h..C7h) |
| lut_data0_i | input | 8 | Read data, resistor 0 table |
| lut_data1_i | input | 8 | Read data, resistor 1 table |
| code0_o | output | 8 | Resistor 0 code |
| code1_o | output | 8 | Resistor 1 code |

## Verification
The hardest case is indexing being turned off while a lookup is still in its two-cycle flight. The returned byte must then be dropped, and the manual values must win on the very next edge. The bench reaches this case with a directed sequence: it issues a sample, clears the enable on the following cycle, and preloads table bytes that differ from the manual values, so that a stale load would show. Random temperatures over the whole signed range are also used. Back-to-back samples exercise both clamps and the pipelined loads.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned N_RES     = 2;
  localparam int unsigned N_ENTRIES = 72;
  localparam int          T_MIN     = -40;
  localparam int unsigned STEP_LOG2 = 1;
  localparam int unsigned TABLE_BASE = 'h80;
endpackage

// File: rtl/tcr_index.sv
module tcr_index #(
  parameter int unsigned TEMP_W    = 8,
  parameter int unsigned N_ENTRIES = tcr_pkg::N_ENTRIES,
  parameter int          T_MIN     = tcr_pkg::T_MIN,
  parameter int unsigned STEP_LOG2 = tcr_pkg::STEP_LOG2,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [TEMP_W-1:0] temp_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned TW = TEMP_W + 2;
  localparam logic signed [TW-1:0] TMIN_S = TW'(T_MIN);
  localparam logic signed [TW-1:0] LAST_S = TW'(N_ENTRIES - 1);

  logic signed [TW-1:0] off;
  logic signed [TW-1:0] step;

  always_comb begin
    off  = $signed({{2{temp_i[TEMP_W-1]}}, temp_i}) - TMIN_S;
    step = off >>> STEP_LOG2;
    if (off < 0)            idx_o = '0;
    else if (step > LAST_S) idx_o = LAST_S[IDX_W-1:0];
    else                    idx_o = step[IDX_W-1:0];
  end
endmodule

// File: rtl/tcr_fetch.sv
module tcr_fetch #(
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned TABLE_BASE = tcr_pkg::TABLE_BASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ret_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(TABLE_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_o   <= 1'b0;
      addr_o <= BASE;
      ret_o  <= 1'b0;
    end else begin
      rd_o  <= start_i;
      ret_o <= rd_o;
      if (start_i) addr_o <= BASE + {{(ADDR_W-IDX_W){1'b0}}, idx_i};
    end
  end

  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;

  // R6
  ret_follows_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_q)
    ret_o |-> $past(rd_o));
  // R2
  addr_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> (addr_o >= BASE && addr_o < BASE + ADDR_W'(tcr_pkg::N_ENTRIES)));
endmodule

// File: rtl/tcr_code_reg.sv
module tcr_code_reg #(
  parameter int unsigned CODE_W = tcr_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              man_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] man_code_i,
  input  logic [CODE_W-1:0] lut_code_i,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_o <= '0;
    else if (man_i)  code_o <= man_code_i;
    else if (load_i) code_o <= lut_code_i;
  end

  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;

  // R7
  manual_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_q)
    $past(man_i) |-> code_o == $past(man_code_i));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_q)
    ($past(!man_i) && $past(!load_i)) |-> $stable(code_o));
  // R1
  always_ff @(posedge clk_i)
    if (!rst_ni) reset_val_chk: assert (code_o == '0);
endmodule

// File: rtl/tcr_code_sel.sv
module tcr_code_sel #(
  parameter int unsigned TEMP_W     = 8,
  parameter int unsigned CODE_W     = tcr_pkg::CODE_W,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned N_ENTRIES  = tcr_pkg::N_ENTRIES,
  parameter int          T_MIN      = tcr_pkg::T_MIN,
  parameter int unsigned STEP_LOG2  = tcr_pkg::STEP_LOG2,
  parameter int unsigned TABLE_BASE = tcr_pkg::TABLE_BASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              temp_valid_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              temp_en_i,
  input  logic [CODE_W-1:0] man_code0_i,
  input  logic [CODE_W-1:0] man_code1_i,
  output logic              lut_rd_o,
  output logic [ADDR_W-1:0] lut_addr_o,
  input  logic [CODE_W-1:0] lut_data0_i,
  input  logic [CODE_W-1:0] lut_data1_i,
  output logic [CODE_W-1:0] code0_o,
  output logic [CODE_W-1:0] code1_o
);
  localparam int unsigned IDX_W = $clog2(N_ENTRIES);
  localparam int unsigned N_RES = tcr_pkg::N_RES;

  logic [IDX_W-1:0]  idx;
  logic              start;
  logic              ret;
  logic [CODE_W-1:0] man_v  [N_RES];
  logic [CODE_W-1:0] lut_v  [N_RES];
  logic [CODE_W-1:0] code_v [N_RES];

  assign start = temp_valid_i & temp_en_i;

  tcr_index #(
    .TEMP_W(TEMP_W), .N_ENTRIES(N_ENTRIES), .T_MIN(T_MIN), .STEP_LOG2(STEP_LOG2)
  ) u_index (
    .temp_i (temp_i),
    .idx_o  (idx)
  );

  tcr_fetch #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .TABLE_BASE(TABLE_BASE)
  ) u_fetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .idx_i   (idx),
    .rd_o    (lut_rd_o),
    .addr_o  (lut_addr_o),
    .ret_o   (ret)
  );

  assign man_v[0] = man_code0_i;
  assign man_v[1] = man_code1_i;
  assign lut_v[0] = lut_data0_i;
  assign lut_v[1] = lut_data1_i;

  for (genvar r = 0; r < N_RES; r++) begin : g_res
    tcr_code_reg #(.CODE_W(CODE_W)) u_reg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .man_i      (~temp_en_i),
      .load_i     (ret),
      .man_code_i (man_v[r]),
      .lut_code_i (lut_v[r]),
      .code_o     (code_v[r])
    );
  end

  assign code0_o = code_v[0];
  assign code1_o = code_v[1];

  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;

  // R5
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_q)
    lut_rd_o |-> $past(temp_valid_i && temp_en_i));
  // R5
  strobe_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_valid_i && temp_en_i) |=> lut_rd_o);
  // R3
  clamp_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && $signed(temp_i) < -40) |=> lut_addr_o == ADDR_W'(TABLE_BASE));
  // R4
  clamp_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && $signed(temp_i) >= 102) |=> lut_addr_o == ADDR_W'(TABLE_BASE + N_ENTRIES - 1));
  // R8
  manual_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !temp_en_i |=> (code0_o == $past(man_code0_i) && code1_o == $past(man_code1_i)));
endmodule

// File: tb/tb_tcr_code_sel.sv
module tb_tcr_code_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       temp_valid = 1'b0;
  logic [7:0] temp = '0;
  logic       temp_en = 1'b0;
  logic [7:0] man0 = '0, man1 = '0;
  logic       lut_rd;
  logic [7:0] lut_addr;
  logic [7:0] d0 = '0, d1 = '0;
  logic [7:0] code0, code1;

  logic [7:0] mem0 [72];
  logic [7:0] mem1 [72];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tcr_code_sel dut (
    .clk_i(clk), .rst_ni(rst_n), .temp_valid_i(temp_valid), .temp_i(temp),
    .temp_en_i(temp_en), .man_code0_i(man0), .man_code1_i(man1),
    .lut_rd_o(lut_rd), .lut_addr_o(lut_addr), .lut_data0_i(d0), .lut_data1_i(d1),
    .code0_o(code0), .code1_o(code1)
  );

  // table memory model: data returns the cycle after the strobe
  always @(posedge clk)
    if (lut_rd && lut_addr >= 8'h80 && lut_addr <= 8'hC7) begin
      d0 <= mem0[lut_addr - 8'h80];
      d1 <= mem1[lut_addr - 8'h80];
    end

  function automatic int exp_idx(int t);
    int o;
    o = t + 40;
    if (o < 0) return 0;
    o = o >> 1;
    return (o > 71) ? 71 : o;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one sample; checks strobe/address then codes
  task automatic sample(int t, string req);
    int i;
    i = exp_idx(t);
    @(negedge clk);
    temp = 8'(t); temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
    chk({req, " strobe"}, int'(lut_rd), 1);
    chk({req, " addr"}, int'(lut_addr), 128 + i);
    @(negedge clk);
    @(negedge clk);
    chk({req, " code0"}, int'(code0), int'(mem0[i]));
    chk({req, " code1"}, int'(code1), int'(mem1[i]));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1451));
    for (int k = 0; k < 72; k++) begin
      mem0[k] = 8'($urandom);
      mem1[k] = 8'($urandom);
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 rst code0", int'(code0), 0);
    chk("R1 rst code1", int'(code1), 0);
    chk("R1 rst strobe", int'(lut_rd), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 post code0", int'(code0), 0);
    chk("R1 post code1", int'(code1), 0);

    // R5: no strobe in manual mode
    temp = 8'd20; temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
    chk("R5 no strobe manual", int'(lut_rd), 0);

    // R7 manual
    man0 = 8'h5A; man1 = 8'hC3;
    @(negedge clk);
    chk("R7 man0", int'(code0), 8'h5A);
    chk("R7 man1", int'(code1), 8'hC3);

    // R9 enable: hold without sample
    temp_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 hold0", int'(code0), 8'h5A);
    chk("R9 hold1", int'(code1), 8'hC3);

    // R2/R6 directed
    sample(-40, "R2");
    sample(25, "R6");
    sample(101, "R2");
    // R3/R4 clamps
    sample(-128, "R3");
    sample(-41, "R3");
    sample(102, "R4");
    sample(127, "R4");

    // R9 hold between loads
    repeat (3) @(negedge clk);
    chk("R9 between", int'(code0), int'(mem0[71]));

    // R8: disable while lookup in flight
    mem0[exp_idx(0)] = 8'h11; mem1[exp_idx(0)] = 8'h22;
    man0 = 8'hEE; man1 = 8'hDD;
    @(negedge clk);
    temp = 8'd0; temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0; temp_en = 1'b0;
    @(negedge clk);
    chk("R8 next clk0", int'(code0), 8'hEE);
    @(negedge clk);
    @(negedge clk);
    chk("R8 discard0", int'(code0), 8'hEE);
    chk("R8 discard1", int'(code1), 8'hDD);
    temp_en = 1'b1;

    // R10 back to back
    @(negedge clk);
    temp = 8'(-10); temp_valid = 1'b1;
    @(negedge clk);
    temp = 8'd60;
    @(negedge clk);
    temp_valid = 1'b0;
    @(negedge clk);
    chk("R10 first0", int'(code0), int'(mem0[exp_idx(-10)]));
    chk("R10 first1", int'(code1), int'(mem1[exp_idx(-10)]));
    @(negedge clk);
    chk("R10 second0", int'(code0), int'(mem0[exp_idx(60)]));
    chk("R10 second1", int'(code1), int'(mem1[exp_idx(60)]));

    // random sweep over the signed range
    for (int n = 0; n < 300; n++) begin
      int t;
      t = int'($signed(8'($urandom)));
      sample(t, "R2 rnd");
    end

    // R7 random manual values
    temp_en = 1'b0;
    for (int n = 0; n < 20; n++) begin
      logic [7:0] a, b;
      a = 8'($urandom); b = 8'($urandom);
      man0 = a; man1 = b;
      @(negedge clk);
      chk("R7 rnd0", int'(code0), int'(a));
      chk("R7 rnd1", int'(code1), int'(b));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule